// File: doc/BRIEF.md
# Wiper Position Register with Tap Decoder

This block holds the wiper position of one digitally stepped potentiometer channel. An 8-bit volatile register stores the position, and a registered decoder turns it into a one-hot vector of 256 tap-select lines. Only one line is active at a time. Tap 0 sits at the low end of the resistor string and tap 255 at the high end.

The position can change in four ways. The host can write a byte directly. The host can copy one of the channel's stored data slots in parallel. The position can move one tap up or down per step pulse. The position is also reloaded from data slot 0 when power becomes good. A bus decoder elsewhere on the chip turns serial commands into the strobes used here. That decoder produces one step strobe, carrying a direction, for each clock pulse of an up/down sequence. The nonvolatile slots themselves live outside the block; their current contents arrive on a flat input bus.

Top module: `wiper_tap_reg`

## Requirements
- R1: While `rstN` is low, and in the first cycle after reset, `wiperPos` is 00h and only `tapSel[0]` is set.
- R2: `tapSel` always has exactly one bit set. That bit's index equals the value `wiperPos` held one clock earlier: bit 0 is the low terminal (00h) and bit 255 is the high terminal (FFh).
- R3: A `wrStb` sampled at a rising edge makes `wiperPos` equal `wrData` after that edge.
- R4: An `xferStb` sampled at a rising edge loads data slot `xferSel`, where slot k is `drBank[8k+7:8k]`.
- R5: A `stepStb` moves `wiperPos` by one: up when `stepUp` is 1 and down when it is 0. Up and down steps may follow each other in any order.
- R6: Stepping saturates. An up step at FFh leaves FFh, and a down step at 00h leaves 00h.
- R7: In the first cycle `pwrGood` is sampled high after being low (including low during reset), `wiperPos` loads slot 0 (`drBank[7:0]`). Every other strobe in that cycle is ignored.
- R8: When strobes coincide, `wrStb` wins over `xferStb`, and `xferStb` wins over `stepStb`.
- R9: While `pwrGood` is low, all strobes are ignored and `wiperPos` holds its value.
- R10: After `pwrGood` falls and rises again, `wiperPos` equals slot 0, not the value it held before the loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrGood | input | 1 | High when all supplies are stable |
| drBank | input | 32 | Contents of the four data slots, slot k at bits 8k+7:8k |
| wrStb | input | 1 | Direct host write strobe |
| wrData | input | 8 | Byte for the direct write |
| xferStb | input | 1 | Parallel load from a data slot |
| xferSel | input | 2 | Slot index for the parallel load |
| stepStb | input | 1 | Single-tap step strobe |
| stepUp | input | 1 | Step direction, 1 toward the high terminal |
| wiperPos | output | 8 | Current wiper position |
| tapSel | output | 256 | One-hot tap select |

## Verification
Every update of `wiperPos` is due one clock after the edge that samples its strobe. `tapSel` follows one clock later again. The bench drives inputs on the falling edge and compares `wiperPos` with that vector's expected value at the next falling edge. In the same sample it compares `tapSel` with the position expected for the previous vector. The power-up recall, the ignored strobes while power is down and the restore are each due one clock after the `pwrGood` change, and they are sampled in exactly that cycle.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // strobes from the control unit to the datapath, already prioritised
  typedef struct packed {
    logic recall;
    logic ldHost;
    logic ldXfer;
    logic step;
    logic up;
  } wiperCtl_t;
endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwrGood,
  input  logic      wrStb,
  input  logic      xferStb,
  input  logic      stepStb,
  input  logic      stepUp,
  output wiperCtl_t ctl
);
  logic pwrGoodQ;
  logic live;

  always_ff @(posedge clk) begin
    if (!rstN) pwrGoodQ <= 1'b0;
    else       pwrGoodQ <= pwrGood;
  end

  always_comb begin
    ctl.recall = pwrGood & ~pwrGoodQ;
    live       = pwrGood & pwrGoodQ;
    ctl.ldHost = live & wrStb;
    ctl.ldXfer = live & xferStb & ~wrStb;
    ctl.step   = live & stepStb & ~wrStb & ~xferStb;
    ctl.up     = stepUp;
  end
endmodule

// File: rtl/wiper_dpath.sv
module wiper_dpath
  import wiper_pkg::*;
#(
  parameter int POS_W  = 8,
  parameter int NUM_DR = 4,
  localparam int SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
  localparam int TAPS  = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wiperCtl_t               ctl,
  input  logic [NUM_DR*POS_W-1:0] drBank,
  input  logic [POS_W-1:0]        wrData,
  input  logic [SEL_W-1:0]        xferSel,
  output logic [POS_W-1:0]        wiperPos,
  output logic [TAPS-1:0]         tapSel
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] slot [NUM_DR];
  logic [POS_W-1:0] xferVal;
  logic [POS_W-1:0] stepVal;
  logic [POS_W-1:0] posNext;
  logic [TAPS-1:0]  tapNext;

  for (genvar k = 0; k < NUM_DR; k++) begin : g_slot
    assign slot[k] = drBank[k*POS_W +: POS_W];
  end

  always_comb begin
    xferVal = slot[0];
    for (int k = 0; k < NUM_DR; k++)
      if (xferSel == SEL_W'(k)) xferVal = slot[k];
  end

  always_comb begin
    if (ctl.up) stepVal = (wiperPos == POS_MAX) ? POS_MAX : wiperPos + 1'b1;
    else        stepVal = (wiperPos == POS_MIN) ? POS_MIN : wiperPos - 1'b1;
  end

  always_comb begin
    if (ctl.recall)      posNext = slot[0];
    else if (ctl.ldHost) posNext = wrData;
    else if (ctl.ldXfer) posNext = xferVal;
    else if (ctl.step)   posNext = stepVal;
    else                 posNext = wiperPos;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapNext[t] = (wiperPos == POS_W'(t));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wiperPos <= '0;
      tapSel   <= TAPS'(1);
    end else begin
      wiperPos <= posNext;
      tapSel   <= tapNext;
    end
  end
endmodule

// File: rtl/wiper_tap_reg.sv
module wiper_tap_reg
  import wiper_pkg::*;
#(
  parameter int POS_W  = 8,
  parameter int NUM_DR = 4,
  localparam int SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
  localparam int TAPS  = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pwrGood,
  input  logic [NUM_DR*POS_W-1:0] drBank,
  input  logic                    wrStb,
  input  logic [POS_W-1:0]        wrData,
  input  logic                    xferStb,
  input  logic [SEL_W-1:0]        xferSel,
  input  logic                    stepStb,
  input  logic                    stepUp,
  output logic [POS_W-1:0]        wiperPos,
  output logic [TAPS-1:0]         tapSel
);
  wiperCtl_t ctlSt;

  wiper_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .wrStb(wrStb),
    .xferStb(xferStb), .stepStb(stepStb), .stepUp(stepUp), .ctl(ctlSt)
  );

  wiper_dpath #(.POS_W(POS_W), .NUM_DR(NUM_DR)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctlSt), .drBank(drBank), .wrData(wrData),
    .xferSel(xferSel), .wiperPos(wiperPos), .tapSel(tapSel)
  );
endmodule

// File: rtl/wiper_tap_chk.sv
module wiper_tap_chk
  import wiper_pkg::*;
#(
  parameter int POS_W = 8,
  localparam int TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrGood,
  input logic [POS_W-1:0] slot0,
  input logic [POS_W-1:0] wiperPos,
  input logic [TAPS-1:0]  tapSel,
  input wiperCtl_t        st
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  a_r2_one_tap: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel) == 1);

  a_r2_tap_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> tapSel[$past(wiperPos)]);

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rstN)
    (st.step && st.up && !st.ldHost && !st.ldXfer && !st.recall && wiperPos != POS_MAX)
      |=> wiperPos == POS_W'($past(wiperPos) + 1'b1));

  a_r6_sat_high: assert property (@(posedge clk) disable iff (!rstN)
    (st.step && st.up && !st.ldHost && !st.ldXfer && !st.recall && wiperPos == POS_MAX)
      |=> wiperPos == POS_MAX);

  a_r6_sat_low: assert property (@(posedge clk) disable iff (!rstN)
    (st.step && !st.up && !st.ldHost && !st.ldXfer && !st.recall && wiperPos == '0)
      |=> wiperPos == '0);

  a_r7_recall: assert property (@(posedge clk) disable iff (!rstN)
    st.recall |=> wiperPos == $past(slot0));

  a_r9_hold_unpowered: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> $stable(wiperPos));
endmodule

bind wiper_tap_reg wiper_tap_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .slot0(drBank[POS_W-1:0]),
  .wiperPos(wiperPos), .tapSel(tapSel), .st(ctlSt)
);

// File: tb/test_wiper_tap_reg.sv
module test_wiper_tap_reg;
  logic         clk = 1'b0;
  logic         rstN;
  logic         pwrGood;
  logic [31:0]  drBank;
  logic         wrStb;
  logic [7:0]   wrData;
  logic         xferStb;
  logic [1:0]   xferSel;
  logic         stepStb;
  logic         stepUp;
  logic [7:0]   wiperPos;
  logic [255:0] tapSel;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] prevExp;

  always #4 clk = ~clk;

  wiper_tap_reg i_wiper_tap_reg (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .drBank(drBank),
    .wrStb(wrStb), .wrData(wrData), .xferStb(xferStb), .xferSel(xferSel),
    .stepStb(stepStb), .stepUp(stepUp), .wiperPos(wiperPos), .tapSel(tapSel)
  );

  // {wr, wrData, xfer, xferSel, step, up, expected position}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 8'h10, 1'b0, 2'd0, 1'b0, 1'b0, 8'h10},  // R3 direct write
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'h11},  // R5 up
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h10},  // R5 down
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 8'hFE},  // R4 slot 1
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'hFF},  // R5 up to top
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'hFF},  // R6 saturate high
    {1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 8'h01},  // R4 slot 2
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00},  // R5 down to bottom
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00},  // R6 saturate low
    {1'b1, 8'h33, 1'b1, 2'd3, 1'b1, 1'b1, 8'h33},  // R8 write beats all
    {1'b0, 8'h00, 1'b1, 2'd3, 1'b1, 1'b0, 8'h80},  // R8 transfer beats step
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 8'h80},  // idle holds
    {1'b1, 8'hFF, 1'b0, 2'd0, 1'b0, 1'b0, 8'hFF},  // R3 write top
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'hFE}   // R5 down from top
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkTap(input string req, input logic [7:0] idx);
    check(req, {31'b0, tapSel[idx] && ($countones(tapSel) == 1)}, 32'd1);
  endtask

  task automatic idle();
    wrStb = 1'b0; xferStb = 1'b0; stepStb = 1'b0; stepUp = 1'b0;
    wrData = '0; xferSel = '0;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; pwrGood = 1'b0;
    drBank = {8'h80, 8'h01, 8'hFE, 8'h5A};
    idle();
    repeat (3) @(negedge clk);
    check("R1 reset pos", {24'b0, wiperPos}, 32'h00);
    checkTap("R1 reset tap", 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset pos", {24'b0, wiperPos}, 32'h00);

    // R7: power becomes good together with other strobes
    pwrGood = 1'b1; wrStb = 1'b1; wrData = 8'h77; stepStb = 1'b1; stepUp = 1'b1;
    @(negedge clk);
    check("R7 recall slot0", {24'b0, wiperPos}, 32'h5A);
    checkTap("R2 tap before recall", 8'h00);
    prevExp = 8'h5A;

    for (int i = 0; i < NV; i++) begin
      {wrStb, wrData, xferStb, xferSel, stepStb, stepUp} = VEC[i][21:8];
      @(negedge clk);
      check($sformatf("R3/R4/R5/R6/R8 vector %0d pos", i), {24'b0, wiperPos}, {24'b0, VEC[i][7:0]});
      checkTap($sformatf("R2 vector %0d tap", i), prevExp);
      prevExp = VEC[i][7:0];
    end
    idle();
    @(negedge clk);
    checkTap("R2 tap settled", 8'hFE);

    // R9: strobes while power is down
    pwrGood = 1'b0; wrStb = 1'b1; wrData = 8'h44; stepStb = 1'b1; stepUp = 1'b1;
    @(negedge clk);
    check("R9 write ignored", {24'b0, wiperPos}, 32'hFE);
    idle(); xferStb = 1'b1; xferSel = 2'd2;
    @(negedge clk);
    check("R9 transfer ignored", {24'b0, wiperPos}, 32'hFE);
    checkTap("R9 tap unchanged", 8'hFE);

    // R10: restore reloads slot 0, not the old position
    idle(); pwrGood = 1'b1;
    @(negedge clk);
    check("R10 restore recalls slot0", {24'b0, wiperPos}, 32'h5A);
    @(negedge clk);
    checkTap("R10 tap after restore", 8'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule